// File: doc/BRIEF.md
# Pipelined Debug Register Access Chain

This block is a boundary-scan data register that reads and writes a small file of internal debug control words, such as breakpoint, watchpoint and vector-catch settings. A debugger loads a 40-bit command into the chain: a direction flag, a 32-bit data word and a 7-bit register address. When the TAP controller passes Update-DR, the command is sent to the register file. Every register access then takes a fixed number of clock cycles, set by a parameter.

Results come back one scan late. On Capture-DR the chain loads the result of the last finished access, so the command shifted in during a scan gets its answer during the following scan. On the way out, the bit that carried the direction flag carries a Ready flag instead. While an access is still running, Ready reads 0 and any new command is dropped, so the host repeats the scan until Ready reads 1. To collect the last real result, the host sends a closing dummy read of address 0 with zero data. The TAP controller is outside this block: its Capture-DR, Shift-DR and Update-DR states arrive as one-cycle strobes that are synchronous to `clk`.

Top module: `dbg_reg_chain`

## Requirements
- R1: After reset, tdo is 0, and the first scan shifts out Ready=1, data 0 and address 0.
- R2: The scan after an accepted write shifts out Ready=1, the written data and the write address. This also holds when the address is outside the register file.
- R3: The scan after an accepted read shifts out Ready=1, the addressed register's contents and the read address.
- R4: The chain shifts least significant bit first, and tdo carries the bit about to leave. Chain bit 0 is the direction flag on input (1 = write, 0 = read) and Ready on output. Bits 32..1 hold the data, LSB at bit 1. Bits 39..33 hold the address, LSB at bit 33.
- R5: A Capture-DR while an access is still running shifts out Ready=0, together with the data and address of the last finished access.
- R6: An Update-DR while an access is running is ignored, and no register changes because of it.
- R7: An accepted access keeps Ready at 0 for exactly ACC_LAT clock cycles. A Capture-DR on the edge that ends the access still reads Ready=0, and a Capture-DR one edge later reads Ready=1 with the new result.
- R8: Registers exist only at addresses 0..NUM_REGS-1. A write to any higher address changes nothing, and a read from a higher address returns 0.
- R9: Writing zero to a register clears it, and a later read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the chain and the register file |
| rst_n | input | 1 | Synchronous active-low reset |
| tdi | input | 1 | Serial data into the chain |
| capture_dr | input | 1 | One-cycle Capture-DR strobe |
| shift_dr | input | 1 | One-cycle-per-bit Shift-DR strobe |
| update_dr | input | 1 | One-cycle Update-DR strobe |
| tdo | output | 1 | Serial data out of the chain (chain bit 0) |

## Verification
Two events can fall on the same clock edge: a pending access finishing and a Capture-DR sampling Ready and the result. The bench sets this up by following a write with exactly ACC_LAT-1 idle cycles before the next scan, so its capture lands on the finishing edge. In that case it expects Ready=0 and the previous result. A run with one more idle cycle must show Ready=1 and the freshly written value. A second overlap, Update-DR arriving while busy, is forced by starting a scan right after a write. It is judged by reading the target register back afterwards.

// File: rtl/dbg_chain_pkg.sv
// Package: shared widths and the chain word layout for the debug register chain.
// Assumes: the direction/ready flag leaves first, then data LSB first, then address.
package dbg_chain_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 7;
    localparam int CHAIN_W = 1 + DATA_W + ADDR_W;

    // Packed so that bit 0 is the flag, bits 32..1 data, bits 39..33 address.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              flag;
    } chain_word_t;
endpackage

// File: rtl/dbg_shift_reg.sv
// Module: serial capture/shift register for the debug chain.
// Loads a parallel word on capture and moves one bit toward tdo per shift.
// Assumes capture and shift never arrive together (the TAP controller guarantees it).
module dbg_shift_reg #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tdi,
    input  logic         capture,
    input  logic         shift,
    input  logic [W-1:0] cap_val,
    output logic         tdo,
    output logic [W-1:0] par_out
);
    logic [W-1:0] sh_q;

    // Capture has priority; shifting brings tdi into the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)       sh_q <= '0;
        else if (capture) sh_q <= cap_val;
        else if (shift)   sh_q <= {tdi, sh_q[W-1:1]};
    end

    assign tdo     = sh_q[0];
    assign par_out = sh_q;

    // R4
    cap_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> tdo == $past(cap_val[0]));
    // R4
    shift_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !capture) |=> par_out[W-1] == $past(tdi));
endmodule

// File: rtl/dbg_reg_file.sv
// Module: small debug register file with one write port and one read port.
// Holds NUM_REGS words at addresses 0..NUM_REGS-1. Writes to higher
// addresses are dropped and reads from them return zero.
// Assumes NUM_REGS is a power of two and no larger than 2**ADDR_W.
module dbg_reg_file #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

    logic [DATA_W-1:0] mem [NUM_REGS];
    logic              in_range;

    assign in_range = {1'b0, addr} < LIMIT;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // One word: cleared by reset, loaded when addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                mem[i] <= '0;
            else if (we && addr == ADDR_W'(i))         mem[i] <= wdata;
        end
    end

    // Read mux: unmapped addresses read as zero.
    always_comb begin
        rdata = '0;
        if (in_range) rdata = mem[addr[IDX_W-1:0]];
    end

    // R9
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && in_range) |=> mem[$past(addr[IDX_W-1:0])] == $past(wdata));
endmodule

// File: rtl/dbg_access_ctrl.sv
// Module: launches one register access per accepted Update-DR and holds its result.
// An access is accepted only when idle, completes after LAT cycles and
// returns the written data (write) or the register contents (read).
// Assumes LAT >= 1.
module dbg_access_ctrl
    import dbg_chain_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              update,
    input  chain_word_t       cmd,
    input  logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic [ADDR_W-1:0] res_addr,
    output logic [DATA_W-1:0] res_data,
    output logic              we,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] wdata
);
    localparam int CNT_W = $clog2(LAT + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    chain_word_t      cmd_q;
    logic             done;

    assign done  = busy_q && (cnt_q == CNT_W'(1));
    assign ready = !busy_q;

    // Launch on an idle update, count down, and store the result on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            cnt_q    <= '0;
            cmd_q    <= '0;
            res_addr <= '0;
            res_data <= '0;
        end else if (update && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(LAT);
            cmd_q  <= cmd;
        end else if (done) begin
            busy_q   <= 1'b0;
            cnt_q    <= '0;
            res_addr <= cmd_q.addr;
            res_data <= cmd_q.flag ? cmd_q.data : rdata;
        end else if (busy_q) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign we       = done && cmd_q.flag;
    assign acc_addr = cmd_q.addr;
    assign wdata    = cmd_q.data;

    // R6
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (update && busy_q) |=> $stable(cmd_q));
    // R7
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (update && ready) |=> !ready);
    // R7
    finish_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);
    // R2
    write_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_q.flag) |=> res_data == $past(wdata));
endmodule

// File: rtl/dbg_reg_chain.sv
// Module: top of the pipelined debug register access chain.
// Capture-DR loads {result address, result data, Ready}. Update-DR
// launches the shifted-in command. Results appear one scan later.
// Assumes the TAP strobes are one-cycle pulses synchronous to clk.
module dbg_reg_chain
    import dbg_chain_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int ACC_LAT  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tdi,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic update_dr,
    output logic tdo
);
    chain_word_t       cap_word;
    logic [CHAIN_W-1:0] par_word;
    chain_word_t       cmd_word;
    logic              ready;
    logic [ADDR_W-1:0] res_addr;
    logic [DATA_W-1:0] res_data;
    logic              we;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;

    assign cap_word.addr = res_addr;
    assign cap_word.data = res_data;
    assign cap_word.flag = ready;
    assign cmd_word      = chain_word_t'(par_word);

    dbg_shift_reg #(.W(CHAIN_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .tdi     (tdi),
        .capture (capture_dr),
        .shift   (shift_dr),
        .cap_val (cap_word),
        .tdo     (tdo),
        .par_out (par_word)
    );

    dbg_access_ctrl #(.LAT(ACC_LAT)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .update   (update_dr),
        .cmd      (cmd_word),
        .rdata    (rdata),
        .ready    (ready),
        .res_addr (res_addr),
        .res_data (res_data),
        .we       (we),
        .acc_addr (acc_addr),
        .wdata    (wdata)
    );

    dbg_reg_file #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .addr  (acc_addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    // R1
    reset_ready_chk: assert property (@(posedge clk)
        !rst_n |=> (ready && res_addr == '0 && res_data == '0));
endmodule

// File: tb/sim_dbg_reg_chain.sv
`timescale 1ns/1ps
// Bench: walks a vector table of scans, then directed timing cases for Ready.
module sim_dbg_reg_chain;
    localparam int NUM_REGS = 16;
    localparam int ACC_LAT  = 48;
    localparam int NVEC     = 9;

    logic clk = 1'b0;
    logic rst_n, tdi, capture_dr, shift_dr, update_dr;
    logic tdo;
    int   checks = 0;
    int   failures = 0;
    bit   finished = 0;

    always #4 clk = ~clk;

    dbg_reg_chain #(.NUM_REGS(NUM_REGS), .ACC_LAT(ACC_LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .tdi(tdi), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdo(tdo)
    );

    // {dir, data, addr, exp_ready, exp_data, exp_addr}; each row expects the previous row's result.
    localparam logic [79:0] VEC [NVEC] = '{
        {1'b1, 32'hA5A5_0001, 7'd2,    1'b1, 32'h0000_0000, 7'd0},
        {1'b1, 32'h1234_5678, 7'd15,   1'b1, 32'hA5A5_0001, 7'd2},
        {1'b0, 32'h0000_0000, 7'd2,    1'b1, 32'h1234_5678, 7'd15},
        {1'b1, 32'hDEAD_BEEF, 7'h50,   1'b1, 32'hA5A5_0001, 7'd2},
        {1'b0, 32'h0000_0000, 7'h50,   1'b1, 32'hDEAD_BEEF, 7'h50},
        {1'b1, 32'h0000_0000, 7'd2,    1'b1, 32'h0000_0000, 7'h50},
        {1'b0, 32'h0000_0000, 7'd2,    1'b1, 32'h0000_0000, 7'd2},
        {1'b0, 32'h0000_0000, 7'd15,   1'b1, 32'h0000_0000, 7'd2},
        {1'b0, 32'h0000_0000, 7'd0,    1'b1, 32'h1234_5678, 7'd15}
    };

    function automatic string row_req(int i);
        case (i)
            0:       return "R1 R4";
            3, 8:    return "R3 R4";
            5:       return "R8";
            7:       return "R9";
            default: return "R2 R4";
        endcase
    endfunction

    task automatic chk1(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_scan(string req, logic [39:0] got, logic r, logic [31:0] d, logic [6:0] a);
        chk1({req, " ready"}, {31'd0, got[0]}, {31'd0, r});
        chk1({req, " data"}, got[32:1], d);
        chk1({req, " addr"}, {25'd0, got[39:33]}, {25'd0, a});
    endtask

    // One full scan: capture, 40 shifts, update, then idle cycles. Starts right after a negedge.
    task automatic do_scan(logic dir, logic [31:0] d, logic [6:0] a, int idle, output logic [39:0] got);
        logic [39:0] cmd;
        cmd = {a, d, dir};
        capture_dr = 1'b1;
        @(posedge clk); @(negedge clk);
        capture_dr = 1'b0;
        for (int i = 0; i < 40; i++) begin
            got[i]   = tdo;
            tdi      = cmd[i];
            shift_dr = 1'b1;
            @(posedge clk); @(negedge clk);
        end
        shift_dr  = 1'b0;
        update_dr = 1'b1;
        @(posedge clk); @(negedge clk);
        update_dr = 1'b0;
        repeat (idle) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [39:0] got;
        rst_n = 1'b0; tdi = 1'b0; capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the pin
        chk1("R1 tdo after reset", {31'd0, tdo}, 32'd0);

        // Table walk: every scan spaced wider than ACC_LAT so each is accepted.
        for (int i = 0; i < NVEC; i++) begin
            do_scan(VEC[i][79], VEC[i][78:47], VEC[i][46:40], ACC_LAT + 2, got);
            chk_scan(row_req(i), got, VEC[i][39], VEC[i][38:7], VEC[i][6:0]);
        end

        // R5 R6: back-to-back scan while the write runs; its update must be dropped.
        do_scan(1'b1, 32'h1111_0000, 7'd4, 0, got);
        chk_scan("R2", got, 1'b1, 32'h0, 7'd0);
        do_scan(1'b1, 32'h2222_0000, 7'd4, 10, got);
        chk_scan("R5 busy capture", got, 1'b0, 32'h0, 7'd0);
        do_scan(1'b0, 32'h0, 7'd4, ACC_LAT + 2, got);
        chk_scan("R6 first result", got, 1'b1, 32'h1111_0000, 7'd4);
        do_scan(1'b0, 32'h0, 7'd0, ACC_LAT + 2, got);
        chk_scan("R6 register kept", got, 1'b1, 32'h1111_0000, 7'd4);

        // R7: capture on the completing edge still reads Ready=0.
        do_scan(1'b1, 32'hCAFE_0005, 7'd5, ACC_LAT - 1, got);
        do_scan(1'b0, 32'h0, 7'd5, ACC_LAT + 2, got);
        chk_scan("R7 edge capture", got, 1'b0, 32'h0, 7'd0);
        do_scan(1'b0, 32'h0, 7'd0, ACC_LAT + 2, got);
        chk_scan("R7 late read", got, 1'b1, 32'hCAFE_0005, 7'd5);

        // R7: one cycle later the capture sees the new result.
        do_scan(1'b1, 32'h0000_0066, 7'd6, ACC_LAT, got);
        do_scan(1'b0, 32'h0, 7'd0, ACC_LAT + 2, got);
        chk_scan("R7 next edge", got, 1'b1, 32'h0000_0066, 7'd6);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule